// File: doc/BRIEF.md
# Configurable SPI Master Engine

This block is a single-channel serial master. It accepts one word at a time over a valid/ready handshake and shifts the low 8, 16, 24 or 32 bits out on the serial data lines. While it does so it assembles the bits seen on the serial input into a receive word, which it presents with a one-cycle valid strobe. A set of static configuration inputs chooses the serial clock rate, its idle level and sampling edge, and the bit order. They also choose whether one output line or four output lines carry data. Chip-select can be driven automatically per word or held under direct software control. Optional lead and lag periods pad the chip-select window, and a programmable idle gap follows each word.

The configuration inputs are meant to come from a register block outside this engine, and the word interfaces are meant to connect to external queues. The engine holds no queue of its own. It takes a new word only when it is fully idle, after the gap that ended the previous word has expired.

Top module: `spi_master_engine`

## Requirements
- R1: `cfg_size` selects the word length N: 0 gives 8 bits, 1 gives 16, 2 gives 24 and 3 gives 32. Only the low N bits of `tx_data` are sent. In single-line mode there are N serial clock periods, and in quad mode there are N/4. Either way the serial clock toggles twice per period.
- R2: With `cfg_lsb_first`=0, bit N-1 goes first and bit 0 goes last. With `cfg_lsb_first`=1 the order is reversed. In single-line mode the data is on `mosi[0]` and `mosi[3:1]` stay 0.
- R3: With `cfg_quad`=1, each serial clock period carries 4 bits on `mosi[3:0]`. In MSB-first order the first period carries bits N-1..N-4, with bit N-1 on `mosi[3]`. In LSB-first order the first period carries bits 3..0, with bit 0 on `mosi[0]`. In quad mode the received word is 0.
- R4: `sclk` rests at the `cfg_cpol` level whenever the engine is not busy. With `cfg_cpha`=0 the first edge comes one half-period after the data phase begins. With `cfg_cpha`=1 it comes at the start of the data phase. The receiver samples on the leading edge for phase 0 and on the trailing edge for phase 1.
- R5: Each serial half-period lasts `cfg_div`+1 system clocks.
- R6: With `cfg_hw_sel`=1, `cs_n` is low from the cycle after a word is accepted until the data phase and any lag period end. It is high at all other times.
- R7: With `cfg_hw_sel`=0, `cs_n` equals the inverse of `cfg_sel_level` and does not depend on transfers.
- R8: `cfg_lead` adds one full serial period with `cs_n` low before the data phase. `cfg_lag` adds one full serial period after the data phase.
- R9: After each word, `busy` stays high for a further 2*`cfg_gap` half-periods. No new word is accepted before that gap ends.
- R10: While `cfg_enable`=0, `tx_ready` and `busy` are low and `cs_n` is high. Dropping `cfg_enable` during a word abandons the word within one cycle.
- R11: At the end of each data phase `rx_valid` pulses for exactly one cycle. `rx_data` then holds the N received bits right-aligned in their transmit significance, with the upper bits zero.
- R12: `tx_ready` is high only when the engine is enabled and idle. A word offered with `tx_valid` is taken at the first clock edge where both are high, and `busy` rises in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_enable | input | 1 | Global engine enable |
| cfg_cpol | input | 1 | Serial clock idle level |
| cfg_cpha | input | 1 | Serial clock phase select |
| cfg_size | input | 2 | Word length code (8/16/24/32) |
| cfg_quad | input | 1 | 1 selects four data-out lines |
| cfg_lsb_first | input | 1 | 1 sends the least significant bit first |
| cfg_hw_sel | input | 1 | 1 gives automatic chip-select, 0 gives software chip-select |
| cfg_sel_level | input | 1 | Software chip-select request (1 = select) |
| cfg_div | input | DIV_W | Half-period length minus one, in system clocks |
| cfg_lead | input | 1 | Adds a serial period before the data phase |
| cfg_lag | input | 1 | Adds a serial period after the data phase |
| cfg_gap | input | GAP_W | Idle serial periods after deselect |
| tx_valid | input | 1 | Transmit word offered |
| tx_data | input | DATA_W | Transmit word |
| tx_ready | output | 1 | Engine can take a word |
| rx_valid | output | 1 | One-cycle strobe for a received word |
| rx_data | output | DATA_W | Received word, right-aligned |
| sclk | output | 1 | Serial clock |
| cs_n | output | 1 | Active-low chip-select |
| mosi | output | 4 | Serial data out lines |
| miso | input | 1 | Serial data in |
| busy | output | 1 | High from word acceptance until the gap ends |

## Verification
A word is taken at the first edge where `tx_valid` and `tx_ready` are both high. `busy` and the automatic `cs_n` change in the following cycle. `sclk` edges then follow at multiples of `cfg_div`+1 cycles, and `rx_valid` rises in the cycle after the final half-period of the data phase. The bench drives inputs one time unit after the rising edge and takes every reading at the falling edge. It counts whole cycles there: cycles with `busy` high, cycles with `cs_n` low, and cycles before the first `sclk` change. It compares each count with the half-period sum that the requirements give for that configuration. Serial data is captured in the cycle in which the sampling edge of `sclk` appears.

// File: rtl/spim_pkg.sv
package spim_pkg;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_LEAD,
      ST_XFER,
      ST_LAG,
      ST_GAP
   } spim_state_e;

   // word length in bits for a 2-bit size code: 8, 16, 24, 32
   function automatic logic [6:0] word_bits(input logic [1:0] size);
      return (7'(size) + 7'd1) << 3;
   endfunction

endpackage

// File: rtl/spim_divider.sv
module spim_divider #(
   parameter int DIV_W = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  logic [DIV_W-1:0] div,
   output logic             tick
);

   logic [DIV_W-1:0] cnt;

   assign tick = run && (cnt == div);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cnt <= '0;
      else if (!run || tick)
         cnt <= '0;
      else
         cnt <= cnt + 1'b1;
   end

endmodule

// File: rtl/spim_ctrl.sv
module spim_ctrl
   import spim_pkg::*;
#(
   parameter int GAP_W = 6,
   parameter int HC_W  = 7
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             enable,
   input  logic             tx_valid,
   input  logic             lead,
   input  logic             lag,
   input  logic             quad,
   input  logic [1:0]       size,
   input  logic [GAP_W-1:0] gap,
   input  logic             tick,
   output spim_state_e      state,
   output logic [HC_W-1:0]  hcnt,
   output logic             load,
   output logic             shift,
   output logic             sample,
   output logic             done,
   output logic             tx_ready
);

   logic [6:0]      nbits;
   logic [6:0]      slots;
   logic [HC_W-1:0] last;
   logic            end_half;
   logic            in_xfer;
   spim_state_e     after_xfer;
   spim_state_e     after_lag;

   always_comb begin
      nbits = word_bits(size);
      slots = quad ? (nbits >> 2) : nbits;
      unique case (state)
         ST_LEAD, ST_LAG: last = HC_W'(1);
         ST_XFER:         last = HC_W'({slots, 1'b0} - 8'd1);
         ST_GAP:          last = HC_W'({1'b0, gap, 1'b0} - (GAP_W + 2)'(1));
         default:         last = '0;
      endcase
      after_lag  = (gap != '0) ? ST_GAP : ST_IDLE;
      after_xfer = lag ? ST_LAG : after_lag;
   end

   assign end_half = tick && (hcnt == last);
   assign in_xfer  = (state == ST_XFER);
   assign tx_ready = (state == ST_IDLE) && enable;
   assign load     = tx_ready && tx_valid;
   assign shift    = in_xfer && tick && hcnt[0] && (hcnt != last);
   assign sample   = in_xfer && tick && !hcnt[0];
   assign done     = in_xfer && end_half && enable;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state <= ST_IDLE;
         hcnt  <= '0;
      end else if (!enable) begin
         state <= ST_IDLE;
         hcnt  <= '0;
      end else begin
         unique case (state)
            ST_IDLE: begin
               hcnt <= '0;
               if (tx_valid)
                  state <= lead ? ST_LEAD : ST_XFER;
            end
            default: begin
               if (end_half) begin
                  hcnt <= '0;
                  unique case (state)
                     ST_LEAD: state <= ST_XFER;
                     ST_XFER: state <= after_xfer;
                     ST_LAG:  state <= after_lag;
                     default: state <= ST_IDLE;
                  endcase
               end else if (tick) begin
                  hcnt <= hcnt + 1'b1;
               end
            end
         endcase
      end
   end

endmodule

// File: rtl/spim_shifter.sv
module spim_shifter
   import spim_pkg::*;
#(
   parameter int DATA_W  = 32,
   parameter bit QUAD_EN = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic [DATA_W-1:0] load_word,
   input  logic [1:0]        size,
   input  logic              lsb_first,
   input  logic              quad,
   input  logic              shift,
   input  logic              sample,
   input  logic              miso,
   output logic [3:0]        mosi_head,
   output logic [DATA_W-1:0] rx_word
);

   localparam int CW = $clog2(DATA_W + 1);

   logic [CW-1:0]     nbits;
   logic [CW-1:0]     pad;
   logic [DATA_W-1:0] mask;
   logic [DATA_W-1:0] masked;
   logic [DATA_W-1:0] tx_sh;
   logic [DATA_W-1:0] rx_sh;
   logic              quad_on;
   logic              bit1;

   assign nbits  = CW'(word_bits(size));
   assign pad    = CW'(DATA_W) - nbits;
   assign mask   = {DATA_W{1'b1}} >> pad;
   assign masked = load_word & mask;
   assign bit1   = lsb_first ? tx_sh[0] : tx_sh[DATA_W-1];

   generate
      if (QUAD_EN) begin : g_quad
         logic [3:0] head4;
         assign quad_on   = quad;
         assign head4     = lsb_first ? tx_sh[3:0] : tx_sh[DATA_W-1 -: 4];
         assign mosi_head = quad_on ? head4 : {3'b000, bit1};
      end else begin : g_single
         assign quad_on   = 1'b0;
         assign mosi_head = {3'b000, bit1};
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tx_sh <= '0;
         rx_sh <= '0;
      end else if (load) begin
         tx_sh <= lsb_first ? masked : (masked << pad);
         rx_sh <= '0;
      end else begin
         if (shift) begin
            if (lsb_first)
               tx_sh <= quad_on ? (tx_sh >> 4) : (tx_sh >> 1);
            else
               tx_sh <= quad_on ? (tx_sh << 4) : (tx_sh << 1);
         end
         if (sample && !quad_on) begin
            if (lsb_first)
               rx_sh <= {miso, rx_sh[DATA_W-1:1]};
            else
               rx_sh <= {rx_sh[DATA_W-2:0], miso};
         end
      end
   end

   assign rx_word = quad_on ? '0 : (lsb_first ? (rx_sh >> pad) : rx_sh);

endmodule

// File: rtl/spi_master_engine.sv
module spi_master_engine
   import spim_pkg::*;
#(
   parameter int DATA_W  = 32,
   parameter int DIV_W   = 4,
   parameter int GAP_W   = 6,
   parameter bit QUAD_EN = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_enable,
   input  logic              cfg_cpol,
   input  logic              cfg_cpha,
   input  logic [1:0]        cfg_size,
   input  logic              cfg_quad,
   input  logic              cfg_lsb_first,
   input  logic              cfg_hw_sel,
   input  logic              cfg_sel_level,
   input  logic [DIV_W-1:0]  cfg_div,
   input  logic              cfg_lead,
   input  logic              cfg_lag,
   input  logic [GAP_W-1:0]  cfg_gap,
   input  logic              tx_valid,
   input  logic [DATA_W-1:0] tx_data,
   output logic              tx_ready,
   output logic              rx_valid,
   output logic [DATA_W-1:0] rx_data,
   output logic              sclk,
   output logic              cs_n,
   output logic [3:0]        mosi,
   input  logic              miso,
   output logic              busy
);

   localparam int HC_W = (GAP_W + 1 > 7) ? GAP_W + 1 : 7;

   generate
      if (DATA_W < 32 || (DATA_W % 8) != 0) begin : g_bad_data_w
         $error("spi_master_engine: DATA_W must be a multiple of 8 and at least 32");
      end
      if (DIV_W < 1 || GAP_W < 1) begin : g_bad_timer_w
         $error("spi_master_engine: DIV_W and GAP_W must be at least 1");
      end
   endgenerate

   spim_state_e       state;
   logic [HC_W-1:0]   hcnt;
   logic              tick;
   logic              load;
   logic              shift;
   logic              sample;
   logic              done;
   logic              in_frame;
   logic              quad_sel;
   logic [3:0]        head;
   logic [DATA_W-1:0] rx_word;

   assign quad_sel = QUAD_EN ? cfg_quad : 1'b0;

   spim_divider #(.DIV_W(DIV_W)) u_div (
      .clk   (clk),
      .rst_n (rst_n),
      .run   (state != ST_IDLE),
      .div   (cfg_div),
      .tick  (tick)
   );

   spim_ctrl #(.GAP_W(GAP_W), .HC_W(HC_W)) u_ctrl (
      .clk      (clk),
      .rst_n    (rst_n),
      .enable   (cfg_enable),
      .tx_valid (tx_valid),
      .lead     (cfg_lead),
      .lag      (cfg_lag),
      .quad     (quad_sel),
      .size     (cfg_size),
      .gap      (cfg_gap),
      .tick     (tick),
      .state    (state),
      .hcnt     (hcnt),
      .load     (load),
      .shift    (shift),
      .sample   (sample),
      .done     (done),
      .tx_ready (tx_ready)
   );

   spim_shifter #(.DATA_W(DATA_W), .QUAD_EN(QUAD_EN)) u_shift (
      .clk       (clk),
      .rst_n     (rst_n),
      .load      (load),
      .load_word (tx_data),
      .size      (cfg_size),
      .lsb_first (cfg_lsb_first),
      .quad      (cfg_quad),
      .shift     (shift),
      .sample    (sample),
      .miso      (miso),
      .mosi_head (head),
      .rx_word   (rx_word)
   );

   assign in_frame = (state == ST_LEAD) || (state == ST_XFER) || (state == ST_LAG);
   assign busy     = (state != ST_IDLE);
   assign sclk     = (state == ST_XFER) ? (cfg_cpol ^ cfg_cpha ^ hcnt[0]) : cfg_cpol;
   assign cs_n     = cfg_hw_sel ? !(in_frame && cfg_enable) : !(cfg_sel_level && cfg_enable);
   assign mosi     = in_frame ? head : 4'b0000;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rx_valid <= 1'b0;
         rx_data  <= '0;
      end else begin
         rx_valid <= done;
         if (done)
            rx_data <= rx_word;
      end
   end

endmodule

// File: rtl/spim_checker.sv
module spim_checker
   import spim_pkg::*;
#(
   parameter int DATA_W  = 32,
   parameter bit QUAD_EN = 1'b1
) (
   input logic              clk,
   input logic              rst_n,
   input logic              cfg_enable,
   input logic              cfg_cpol,
   input logic              cfg_quad,
   input logic [1:0]        cfg_size,
   input logic              cfg_hw_sel,
   input logic              tx_valid,
   input logic              tx_ready,
   input logic              rx_valid,
   input logic [DATA_W-1:0] rx_data,
   input logic              sclk,
   input logic              cs_n,
   input logic              busy
);

   logic [6:0] nb;
   assign nb = word_bits(cfg_size);

   a_r10_disable_stops: assert property (@(posedge clk) disable iff (!rst_n)
      !cfg_enable |=> !busy);

   a_r10_disable_outputs: assert property (@(posedge clk) disable iff (!rst_n)
      !cfg_enable |-> (cs_n && !tx_ready));

   a_r4_idle_level: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> (sclk == cfg_cpol));

   a_r6_hw_cs_idle: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_hw_sel && !busy) |-> cs_n);

   a_r12_accept: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_valid && tx_ready) |=> busy);

   a_r12_ready_idle: assert property (@(posedge clk) disable iff (!rst_n)
      tx_ready |-> !busy);

   a_r11_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      rx_valid |=> !rx_valid);

   a_r1_zero_ext: assert property (@(posedge clk) disable iff (!rst_n)
      rx_valid |-> ((rx_data >> nb) == '0));

   a_r3_quad_rx_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_valid && cfg_quad && QUAD_EN) |-> (rx_data == '0));

endmodule

bind spi_master_engine spim_checker #(.DATA_W(DATA_W), .QUAD_EN(QUAD_EN)) u_spim_checker (
   .clk        (clk),
   .rst_n      (rst_n),
   .cfg_enable (cfg_enable),
   .cfg_cpol   (cfg_cpol),
   .cfg_quad   (cfg_quad),
   .cfg_size   (cfg_size),
   .cfg_hw_sel (cfg_hw_sel),
   .tx_valid   (tx_valid),
   .tx_ready   (tx_ready),
   .rx_valid   (rx_valid),
   .rx_data    (rx_data),
   .sclk       (sclk),
   .cs_n       (cs_n),
   .busy       (busy)
);

// File: tb/spi_master_engine_bench.sv
`timescale 1ns/1ps
module spi_master_engine_bench;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cfg_enable = 1'b1;
   logic        cfg_cpol = 1'b0;
   logic        cfg_cpha = 1'b0;
   logic [1:0]  cfg_size = 2'd0;
   logic        cfg_quad = 1'b0;
   logic        cfg_lsb_first = 1'b0;
   logic        cfg_hw_sel = 1'b1;
   logic        cfg_sel_level = 1'b0;
   logic [3:0]  cfg_div = 4'd0;
   logic        cfg_lead = 1'b0;
   logic        cfg_lag = 1'b0;
   logic [5:0]  cfg_gap = 6'd0;
   logic        tx_valid = 1'b0;
   logic [31:0] tx_data = 32'd0;
   logic        tx_ready;
   logic        rx_valid;
   logic [31:0] rx_data;
   logic        sclk;
   logic        cs_n;
   logic [3:0]  mosi;
   logic        miso;
   logic        busy;
   logic        miso_flip = 1'b0;

   int n_checks = 0;
   int n_fails  = 0;

   always #5 clk = ~clk;

   assign miso = mosi[0] ^ miso_flip;

   spi_master_engine u_spi_master_engine (
      .clk(clk), .rst_n(rst_n), .cfg_enable(cfg_enable), .cfg_cpol(cfg_cpol),
      .cfg_cpha(cfg_cpha), .cfg_size(cfg_size), .cfg_quad(cfg_quad),
      .cfg_lsb_first(cfg_lsb_first), .cfg_hw_sel(cfg_hw_sel),
      .cfg_sel_level(cfg_sel_level), .cfg_div(cfg_div), .cfg_lead(cfg_lead),
      .cfg_lag(cfg_lag), .cfg_gap(cfg_gap), .tx_valid(tx_valid), .tx_data(tx_data),
      .tx_ready(tx_ready), .rx_valid(rx_valid), .rx_data(rx_data), .sclk(sclk),
      .cs_n(cs_n), .mosi(mosi), .miso(miso), .busy(busy)
   );

   // ---------------- monitor (falling edge) ----------------
   int         m_busy, m_cslow, m_edges, m_samples, m_lead, m_rxv, idle_err;
   logic [31:0] m_rx;
   logic [3:0] m_bits [0:63];
   logic       prev_sclk = 1'b0;
   logic       prev_busy = 1'b0;

   initial begin
      m_busy = 0; m_cslow = 0; m_edges = 0; m_samples = 0; m_lead = 0;
      m_rxv = 0; idle_err = 0; m_rx = 32'd0;
   end

   always @(negedge clk) begin
      if (rst_n) begin
         if (busy && !prev_busy) begin
            m_busy = 0; m_cslow = 0; m_edges = 0; m_samples = 0;
            m_lead = 0; m_rxv = 0;
         end
         if (busy) m_busy++;
         if (busy && !cs_n) m_cslow++;
         if (sclk != prev_sclk) begin
            m_edges++;
            if ((cfg_cpha == 1'b0 && sclk != cfg_cpol) ||
                (cfg_cpha == 1'b1 && sclk == cfg_cpol)) begin
               if (m_samples < 64) m_bits[m_samples] = mosi;
               m_samples++;
            end
         end else if (busy && !cs_n && m_edges == 0) begin
            m_lead++;
         end
         if (rx_valid) begin
            m_rxv++;
            m_rx = rx_data;
         end
         if (!busy && sclk != cfg_cpol) idle_err++;
      end
      prev_sclk = sclk;
      prev_busy = busy;
   end

   // ---------------- helpers ----------------
   task automatic check(input bit ok, input string req, input string what,
                        input logic [31:0] act, input logic [31:0] exp);
      n_checks++;
      if (!ok) begin
         n_fails++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   task automatic step();
      @(posedge clk);
      #1;
   endtask

   task automatic summary();
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
   endtask

   task automatic send_word(input logic [31:0] w);
      tx_data  = w;
      tx_valid = 1'b1;
      step();
      while (!busy) step();
      tx_valid = 1'b0;
      while (busy) step();
      repeat (3) step();
   endtask

   // Check one finished word against the configuration it ran under
   task automatic check_word(input logic [31:0] w);
      int nb, slots, h, bad;
      logic [31:0] mask, rx_exp;
      logic [3:0]  exp4, got4;
      nb    = 8 * (int'(cfg_size) + 1);
      slots = cfg_quad ? nb / 4 : nb;
      h     = int'(cfg_div) + 1;
      mask  = (nb == 32) ? 32'hFFFF_FFFF : ((32'h1 << nb) - 32'h1);
      check(m_edges == 2 * slots, "R1", "sclk edge count", m_edges, 2 * slots);
      check(m_samples == slots, "R1", "sampled periods", m_samples, slots);
      bad = 0; exp4 = 4'h0; got4 = 4'h0;
      for (int s = 0; s < slots && s < 64; s++) begin
         logic [3:0] e;
         if (cfg_quad)
            e = cfg_lsb_first ? w[4*s +: 4] : w[nb-1-4*s -: 4];
         else
            e = {3'b000, cfg_lsb_first ? w[s] : w[nb-1-s]};
         if (m_bits[s] !== e && bad == 0) begin
            exp4 = e; got4 = m_bits[s];
         end
         if (m_bits[s] !== e) bad++;
      end
      if (cfg_quad) check(bad == 0, "R3", "quad line data", 32'(got4), 32'(exp4));
      else          check(bad == 0, "R2", "serial bit order", 32'(got4), 32'(exp4));
      check(m_rxv == 1, "R11", "rx_valid pulse count", m_rxv, 1);
      rx_exp = cfg_quad ? 32'd0 : ((w ^ {32{miso_flip}}) & mask);
      check(m_rx == rx_exp, cfg_quad ? "R3" : "R11", "received word", m_rx, rx_exp);
      check(m_busy == (2*slots + 2*int'(cfg_lead) + 2*int'(cfg_lag) + 2*int'(cfg_gap)) * h,
            "R9", "busy cycles (R5 half period)", m_busy,
            (2*slots + 2*int'(cfg_lead) + 2*int'(cfg_lag) + 2*int'(cfg_gap)) * h);
      if (cfg_hw_sel) begin
         check(m_cslow == (2*slots + 2*int'(cfg_lead) + 2*int'(cfg_lag)) * h,
               "R6", "cs_n low cycles (R8)", m_cslow,
               (2*slots + 2*int'(cfg_lead) + 2*int'(cfg_lag)) * h);
         check(m_lead == (2*int'(cfg_lead) + (cfg_cpha ? 0 : 1)) * h,
               "R8", "cycles before first edge (R4)", m_lead,
               (2*int'(cfg_lead) + (cfg_cpha ? 0 : 1)) * h);
      end else begin
         check(m_cslow == 0, "R7", "cs_n low cycles under software select", m_cslow, 0);
      end
   endtask

   // ---------------- stimulus ----------------
   initial begin
      repeat (4) step();
      rst_n = 1'b1;
      step();
      // reset state
      check(cs_n == 1'b1, "R6", "cs_n after reset", cs_n, 1);
      check(busy == 1'b0, "R12", "busy after reset", busy, 0);
      check(sclk == 1'b0, "R4", "sclk after reset", sclk, 0);
      check(rx_valid == 1'b0, "R11", "rx_valid after reset", rx_valid, 0);
      check(tx_ready == 1'b1, "R12", "tx_ready after reset", tx_ready, 1);

      // R10: disabled engine ignores offered words and holds cs_n high
      begin
         int bad10;
         bad10 = 0;
         cfg_enable = 1'b0; cfg_hw_sel = 1'b0; cfg_sel_level = 1'b1;
         tx_data = 32'hDEAD_BEEF; tx_valid = 1'b1;
         for (int k = 0; k < 20; k++) begin
            step();
            if (busy || !cs_n || tx_ready) bad10++;
         end
         tx_valid = 1'b0;
         check(bad10 == 0, "R10", "disabled cycles with activity", bad10, 0);
      end

      // R7: software select follows the select level
      cfg_enable = 1'b1; cfg_sel_level = 1'b1;
      step();
      check(cs_n == 1'b0, "R7", "cs_n with select level 1", cs_n, 0);
      cfg_sel_level = 1'b0;
      step();
      check(cs_n == 1'b1, "R7", "cs_n with select level 0", cs_n, 1);
      cfg_size = 2'd1; cfg_div = 4'd1;
      send_word(32'h0000_9A3C);
      check_word(32'h0000_9A3C);

      // main sweep over size, quad, order, polarity, phase, timing
      cfg_hw_sel = 1'b1;
      for (int i = 0; i < 64; i++) begin
         logic [31:0] w;
         cfg_size      = i[1:0];
         cfg_quad      = i[2];
         cfg_lsb_first = i[3];
         cfg_cpol      = i[4];
         cfg_cpha      = i[5];
         cfg_div       = 4'(i % 3);
         cfg_lead      = i[0] ^ i[3];
         cfg_lag       = i[1] ^ i[4];
         cfg_gap       = 6'((i * 5) % 4);
         miso_flip     = i[2] ^ i[5];
         w = 32'hA5C3_1E69 ^ (32'(i) * 32'h0123_4567);
         step();
         send_word(w);
         check_word(w);
      end

      // boundary: largest divider and gap, 32-bit word (R5, R9)
      cfg_size = 2'd3; cfg_quad = 1'b0; cfg_lsb_first = 1'b1; cfg_cpol = 1'b1;
      cfg_cpha = 1'b0; cfg_div = 4'd15; cfg_lead = 1'b1; cfg_lag = 1'b1;
      cfg_gap = 6'd63; miso_flip = 1'b1;
      step();
      send_word(32'h8000_0001);
      check_word(32'h8000_0001);

      // R12: back-to-back offer only accepted after the gap ends
      cfg_div = 4'd0; cfg_gap = 6'd2; cfg_lead = 1'b0; cfg_lag = 1'b0; cfg_size = 2'd0;
      step();
      begin
         int ready_in_gap;
         ready_in_gap = 0;
         tx_data = 32'h0000_00C5; tx_valid = 1'b1;
         step();
         while (busy) begin
            if (tx_ready) ready_in_gap++;
            step();
         end
         check(ready_in_gap == 0, "R12", "tx_ready while busy", ready_in_gap, 0);
         check(tx_ready == 1'b1, "R9", "tx_ready after gap", tx_ready, 1);
         tx_valid = 1'b0;
      end
      repeat (3) step();

      // R10: dropping enable mid-word abandons it
      cfg_div = 4'd15; cfg_size = 2'd3; cfg_gap = 6'd0;
      step();
      tx_data = 32'h1234_5678; tx_valid = 1'b1;
      step();
      tx_valid = 1'b0;
      repeat (10) step();
      check(busy == 1'b1, "R10", "busy before abort", busy, 1);
      cfg_enable = 1'b0;
      step();
      check(busy == 1'b0, "R10", "busy after abort", busy, 0);
      check(cs_n == 1'b1, "R10", "cs_n after abort", cs_n, 1);
      check(sclk == cfg_cpol, "R4", "sclk after abort", sclk, 32'(cfg_cpol));
      cfg_enable = 1'b1;
      repeat (3) step();

      check(idle_err == 0, "R4", "idle cycles with sclk off its rest level", idle_err, 0);

      summary();
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      n_checks++;
      n_fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
      $finish;
   end

endmodule